// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from power-up to normal operation. It drives the chip-select, row-strobe, column-strobe and write-enable pins plus the address bus. A single pulse on `autoStart` runs the whole bring-up by itself: it waits out a power-up interval, issues a NOP, precharges all banks, issues a fixed number of auto-refresh cycles and then loads the mode register. Each command lasts one clock, and a programmable quiet interval follows it.

An 8-bit control register also allows single commands to be issued by hand. A 3-bit command field selects the command, and a pulse on `issue` launches it. The same register holds the CAS-latency choice that goes into the mode value, and a refresh-rate field. The refresh-rate field only accepts writes once bring-up has finished, so periodic refresh cannot start early. The datapath and the sequencing control are separate modules, and the control passes strobes to the datapath.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and right after it, all four command pins are high (deselect), the address is 0, `busy`, `initDone` and `refreshEn` are 0 and `refreshRate` is 0.
- R2: Writing `regData` with `regWrite` high stores bits 7:5 as the command field (0 normal, no command; 1 NOP; 2 precharge all; 3 mode register set; 4 auto-refresh; 5 to 7 reserved) and bit 4 as the CAS-latency select (1 = latency 3, the reset value; 0 = latency 2). A pulse on `issue` while idle and past power-up sends the selected command exactly once. Field values 0 and 5 to 7 send nothing and leave `busy` low.
- R3: The pin codes, in the order {csN, rasN, casN, weN}, are: NOP 0111, precharge-all 0010 with only address bit 10 high, auto-refresh 0001 with address 0, and mode register set 0000. Deselect is 1111 with address 0. Each command appears for exactly one clock.
- R4: Mode register set drives an address with bits 2:0 = 010 (burst of 4), bit 3 = 1 (interleaved wrap) and bits 6:4 = 011 for latency 3 or 010 for latency 2. All higher bits are 0, so the address is 0x3A or 0x2A.
- R5: A sampled `autoStart` pulse produces, in this order: NOP, precharge-all, REF_COUNT (8) auto-refreshes and one mode register set.
- R6: In the automatic sequence the precharge immediately follows the NOP on the next clock. Exactly T_RP deselect clocks follow the precharge, and exactly T_RC deselect clocks follow each refresh.
- R7: No command appears until more than PWRUP_CYC clock edges have passed since reset was released. An `autoStart` accepted earlier waits for that point. An `issue` pulse before that point is ignored.
- R8: `busy` is high from the clock after `autoStart` is accepted. `autoStart` clears `initDone`. `initDone` rises exactly T_MRD clocks after the mode-register-set clock, and `busy` falls at the same time.
- R9: `autoStart` and `issue` pulses that arrive while `busy` is high have no effect on the pins.
- R10: The refresh-rate field (bits 3:0) only takes a write while `initDone` is 1 and otherwise keeps its value. `refreshEn` is high exactly when `initDone` is 1 and the rate is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrite | input | 1 | Write strobe for the control register |
| regData | input | 8 | Control register write data |
| autoStart | input | 1 | Start the full bring-up sequence |
| issue | input | 1 | Send the single command chosen by the command field |
| busy | output | 1 | Sequence or single command in progress |
| initDone | output | 1 | Bring-up finished, normal operation |
| refreshEn | output | 1 | Periodic refresh allowed |
| refreshRate | output | 4 | Stored refresh-rate field |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | SDRAM address bus |

## Verification
The hardest situations to reach from the ports are the ones where a trigger lands in an awkward state. One is a trigger while the power-up counter is still running. Another is a second trigger during the long chain of refresh waits. Neither shows up on the pins unless the design handles it wrongly. The stimulus therefore sets a valid command field and pulses `issue` within the first few clocks after reset. It then starts the full sequence and fires both triggers again in the middle of it. A scoreboard holds the exact list of commands expected, so any extra or misplaced command stands out as an unexpected entry. The refresh-rate lock is exercised by writing a nonzero rate before bring-up and reading it back at the port.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmdKind_t;

  typedef enum logic [1:0] {
    WAIT_RP,
    WAIT_RC,
    WAIT_MRD
  } waitSel_t;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic     issue;
    cmdKind_t kind;
    logic     loadWait;
    waitSel_t waitSel;
    logic     refClr;
    logic     refInc;
    logic     setDone;
    logic     clrDone;
  } seqStrobe_t;

  // Command field encodings (control register bits 7:5)
  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_NOP    = 3'd1;
  localparam logic [2:0] MODE_PRE    = 3'd2;
  localparam logic [2:0] MODE_MRS    = 3'd3;
  localparam logic [2:0] MODE_REF    = 3'd4;

endpackage

// File: rtl/sdinit_datapath.sv
module sdinit_datapath
  import sdinit_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int T_RP      = 2,
  parameter int T_RC      = 6,
  parameter int T_MRD     = 2,
  parameter int REF_COUNT = 8,
  parameter int PWRUP_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              regWrite,
  input  logic [7:0]        regData,
  output logic              powerOk,
  output logic              waitLast,
  output logic              refDone,
  output logic [2:0]        modeField,
  output logic              initDone,
  output logic              refreshEn,
  output logic [3:0]        refreshRate,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr
);

  localparam int T_MAX0 = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int T_MAX  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
  localparam int WAIT_W = $clog2(T_MAX + 1);
  localparam int REF_W  = $clog2(REF_COUNT + 1);
  localparam int PWR_W  = $clog2(PWRUP_CYC + 1);

  logic [PWR_W-1:0]  pwrCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] loadVal;
  logic [REF_W-1:0]  refCnt;
  logic [2:0]        modeReg;
  logic              clSel;
  logic [3:0]        rateReg;
  logic              doneReg;
  logic [3:0]        nxtPins;
  logic [ADDR_W-1:0] nxtAddr;

  // Power-up interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pwrCnt <= '0;
    else if (pwrCnt != PWR_W'(PWRUP_CYC))   pwrCnt <= pwrCnt + 1'b1;
  end
  assign powerOk = (pwrCnt == PWR_W'(PWRUP_CYC));

  // Control register: command field, latency select, locked rate field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_NORMAL;
      clSel   <= 1'b1;
      rateReg <= '0;
    end else if (regWrite) begin
      modeReg <= regData[7:5];
      clSel   <= regData[4];
      if (doneReg) rateReg <= regData[3:0];
    end
  end
  assign modeField   = modeReg;
  assign refreshRate = rateReg;

  // Quiet-interval counter
  always_comb begin
    case (strobe.waitSel)
      WAIT_RP: loadVal = WAIT_W'(T_RP);
      WAIT_RC: loadVal = WAIT_W'(T_RC);
      default: loadVal = WAIT_W'(T_MRD);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadWait)  waitCnt <= loadVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end
  assign waitLast = (waitCnt == WAIT_W'(1));

  // Refresh tally for the automatic sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refCnt <= '0;
    else if (strobe.refClr) refCnt <= '0;
    else if (strobe.refInc) refCnt <= refCnt + 1'b1;
  end
  assign refDone = (refCnt == REF_W'(REF_COUNT));

  // Completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               doneReg <= 1'b0;
    else if (strobe.clrDone) doneReg <= 1'b0;
    else if (strobe.setDone) doneReg <= 1'b1;
  end
  assign initDone  = doneReg;
  assign refreshEn = doneReg && (rateReg != '0);

  // Command pin encoder
  always_comb begin
    nxtPins = 4'b1111;
    nxtAddr = '0;
    if (strobe.issue) begin
      case (strobe.kind)
        CMD_NOP: nxtPins = 4'b0111;
        CMD_PRE: begin
          nxtPins     = 4'b0010;
          nxtAddr[10] = 1'b1;
        end
        CMD_REF: nxtPins = 4'b0001;
        CMD_MRS: begin
          nxtPins      = 4'b0000;
          nxtAddr[6:0] = {1'b0, 1'b1, clSel, 1'b1, 3'b010};
        end
        default: nxtPins = 4'b1111;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= 4'b1111;
      sdAddr                         <= '0;
    end else begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= nxtPins;
      sdAddr                         <= nxtAddr;
    end
  end

  // R7: a selected chip only after the power-up interval
  assert_cmd_after_power_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sdCsN |-> powerOk);

  // R10: the rate field changes only while bring-up is complete
  assert_rate_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rateReg != $past(rateReg)) |-> $past(doneReg));

  // R8: completion flag rises only when the final quiet interval has run out
  assert_done_after_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneReg) |-> (waitCnt == '0));

  // R6: precharge and mode set are always followed by a quiet clock
  assert_quiet_after_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && !sdWeN) |=> sdCsN);

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoStart,
  input  logic       issue,
  input  logic [2:0] modeField,
  input  logic       powerOk,
  input  logic       waitLast,
  input  logic       refDone,
  output seqStrobe_t strobe,
  output logic       busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_NOP, S_PRE, S_WRP, S_REF, S_WRC,
    S_MRS, S_WMRD, S_MAN, S_MWAIT
  } seqState_t;

  seqState_t state, nxtState;
  cmdKind_t  manKind;
  waitSel_t  manWait;

  // Decode the hand-issued command field
  always_comb begin
    manWait = WAIT_RP;
    case (modeField)
      MODE_NOP: manKind = CMD_NOP;
      MODE_PRE: manKind = CMD_PRE;
      MODE_MRS: begin manKind = CMD_MRS; manWait = WAIT_MRD; end
      MODE_REF: begin manKind = CMD_REF; manWait = WAIT_RC;  end
      default:  manKind = CMD_DESEL;
    endcase
  end

  always_comb begin
    nxtState = state;
    strobe   = '0;
    strobe.kind    = CMD_DESEL;
    strobe.waitSel = WAIT_RP;
    case (state)
      S_IDLE: begin
        if (autoStart) begin
          nxtState       = S_PWR;
          strobe.clrDone = 1'b1;
          strobe.refClr  = 1'b1;
        end else if (issue && powerOk && (manKind != CMD_DESEL)) begin
          nxtState = S_MAN;
        end
      end
      S_PWR: if (powerOk) nxtState = S_NOP;
      S_NOP: begin
        strobe.issue = 1'b1;
        strobe.kind  = CMD_NOP;
        nxtState     = S_PRE;
      end
      S_PRE: begin
        strobe.issue    = 1'b1;
        strobe.kind     = CMD_PRE;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_RP;
        nxtState        = S_WRP;
      end
      S_WRP: if (waitLast) nxtState = S_REF;
      S_REF: begin
        strobe.issue    = 1'b1;
        strobe.kind     = CMD_REF;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_RC;
        strobe.refInc   = 1'b1;
        nxtState        = S_WRC;
      end
      S_WRC: if (waitLast) nxtState = refDone ? S_MRS : S_REF;
      S_MRS: begin
        strobe.issue    = 1'b1;
        strobe.kind     = CMD_MRS;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_MRD;
        nxtState        = S_WMRD;
      end
      S_WMRD: begin
        if (waitLast) begin
          strobe.setDone = 1'b1;
          nxtState       = S_IDLE;
        end
      end
      S_MAN: begin
        strobe.issue = 1'b1;
        strobe.kind  = manKind;
        if (manKind == CMD_NOP) begin
          nxtState = S_IDLE;
        end else begin
          strobe.loadWait = 1'b1;
          strobe.waitSel  = manWait;
          nxtState        = S_MWAIT;
        end
      end
      S_MWAIT: if (waitLast) nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

  assign busy = (state != S_IDLE);

  // R5: mode register set only once every refresh of the sequence is counted
  assert_mrs_after_refresh_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MRS) |-> refDone);

  // R9: a running sequence is never restarted
  assert_no_restart_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_PWR) |=> (state != S_PWR));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int T_RP      = 2,
  parameter int T_RC      = 6,
  parameter int T_MRD     = 2,
  parameter int REF_COUNT = 8,
  parameter int PWRUP_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [7:0]        regData,
  input  logic              autoStart,
  input  logic              issue,
  output logic              busy,
  output logic              initDone,
  output logic              refreshEn,
  output logic [3:0]        refreshRate,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr
);

  seqStrobe_t strobe;
  logic       powerOk;
  logic       waitLast;
  logic       refDone;
  logic [2:0] modeField;

  sdinit_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .autoStart (autoStart),
    .issue     (issue),
    .modeField (modeField),
    .powerOk   (powerOk),
    .waitLast  (waitLast),
    .refDone   (refDone),
    .strobe    (strobe),
    .busy      (busy)
  );

  sdinit_datapath #(
    .ADDR_W    (ADDR_W),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD),
    .REF_COUNT (REF_COUNT),
    .PWRUP_CYC (PWRUP_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrite    (regWrite),
    .regData     (regData),
    .powerOk     (powerOk),
    .waitLast    (waitLast),
    .refDone     (refDone),
    .modeField   (modeField),
    .initDone    (initDone),
    .refreshEn   (refreshEn),
    .refreshRate (refreshRate),
    .sdCsN       (sdCsN),
    .sdRasN      (sdRasN),
    .sdCasN      (sdCasN),
    .sdWeN       (sdWeN),
    .sdAddr      (sdAddr)
  );

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int ADDR_W    = 13;
  localparam int T_RP      = 2;
  localparam int T_RC      = 6;
  localparam int T_MRD     = 2;
  localparam int REF_COUNT = 8;
  localparam int PWRUP_CYC = 20;

  localparam logic [3:0] P_DESEL = 4'b1111;
  localparam logic [3:0] P_NOP   = 4'b0111;
  localparam logic [3:0] P_PRE   = 4'b0010;
  localparam logic [3:0] P_REF   = 4'b0001;
  localparam logic [3:0] P_MRS   = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [7:0] regData = 8'h00;
  logic autoStart = 1'b0;
  logic issue = 1'b0;
  logic busy, initDone, refreshEn;
  logic [3:0] refreshRate;
  logic sdCsN, sdRasN, sdCasN, sdWeN;
  logic [ADDR_W-1:0] sdAddr;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .REF_COUNT(REF_COUNT), .PWRUP_CYC(PWRUP_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regData(regData),
    .autoStart(autoStart), .issue(issue), .busy(busy), .initDone(initDone),
    .refreshEn(refreshEn), .refreshRate(refreshRate), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr)
  );

  typedef struct {
    logic [3:0]        pins;
    logic [ADDR_W-1:0] addr;
    int                gap;
    int                req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cmdSeen = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushCmd(input logic [3:0] p, input logic [ADDR_W-1:0] a,
                         input int g, input int r);
    expItem_t e;
    e.pins = p; e.addr = a; e.gap = g; e.req = r;
    expQ.push_back(e);
  endtask

  // R5/R6/R4: the full bring-up as seen on the pins
  task automatic pushAuto(input bit cl3);
    pushCmd(P_NOP, '0, -1, 5);
    pushCmd(P_PRE, ADDR_W'(13'h400), 0, 6);
    pushCmd(P_REF, '0, T_RP, 6);
    for (int i = 1; i < REF_COUNT; i++) pushCmd(P_REF, '0, T_RC, 6);
    pushCmd(P_MRS, cl3 ? ADDR_W'(8'h3A) : ADDR_W'(8'h2A), T_RC, 4);
  endtask

  task automatic writeReg(input logic [2:0] mode, input bit cl3, input logic [3:0] rate);
    @(negedge clk);
    regWrite = 1'b1;
    regData  = {mode, cl3, rate};
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); autoStart = 1'b1;
    @(negedge clk); autoStart = 1'b0;
  endtask

  task automatic pulseIssue();
    @(negedge clk); issue = 1'b1;
    @(negedge clk); issue = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard on every non-deselect clock
  initial begin
    int edgeCnt = 0;
    int gap = 0;
    int mrsCyc = -1000;
    bit firstNop = 1'b1;
    bit prevDone = 1'b0;
    expItem_t e;
    logic [3:0] pins;
    forever begin
      @(posedge clk); #5;
      if (rstN) begin
        edgeCnt++;
        pins = {sdCsN, sdRasN, sdCasN, sdWeN};
        if (pins != P_DESEL) begin
          cmdSeen++;
          if (firstNop) begin
            // R7: nothing before the power-up interval
            check(edgeCnt > PWRUP_CYC, "R7", "first command edge", edgeCnt, PWRUP_CYC + 1);
            firstNop = 1'b0;
          end
          if (expQ.size() == 0) begin
            check(1'b0, "R9", "unexpected command", pins, P_DESEL);
          end else begin
            e = expQ.pop_front();
            check(pins == e.pins, $sformatf("R%0d", e.req), "pins", pins, e.pins);
            // R3: address per command
            check(sdAddr == e.addr, "R3", "address", sdAddr, e.addr);
            if (e.gap >= 0)
              check(gap == e.gap, "R6", "deselect gap", gap, e.gap);
          end
          if (pins == P_MRS) mrsCyc = edgeCnt;
          gap = 0;
        end else begin
          gap++;
        end
        if (initDone && !prevDone)
          check(edgeCnt - mrsCyc == T_MRD, "R8", "done after mode set", edgeCnt - mrsCyc, T_MRD);
        prevDone = initDone;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sdCsN, sdRasN, sdCasN, sdWeN} == P_DESEL, "R1", "pins", {sdCsN, sdRasN, sdCasN, sdWeN}, P_DESEL);
    check(sdAddr == '0, "R1", "addr", sdAddr, 0);
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(initDone == 1'b0, "R1", "initDone", initDone, 0);
    check(refreshEn == 1'b0, "R1", "refreshEn", refreshEn, 0);
    check(refreshRate == 4'd0, "R1", "refreshRate", refreshRate, 0);
    rstN = 1'b1;

    // R10: rate write before bring-up is dropped
    writeReg(3'd1, 1'b1, 4'd3);
    check(refreshRate == 4'd0, "R10", "rate locked", refreshRate, 0);
    // R7: hand NOP before power-up is ignored
    seen = cmdSeen;
    pulseIssue();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7", "busy after early issue", busy, 0);
    check(cmdSeen == seen, "R7", "commands after early issue", cmdSeen, seen);

    // R5: full sequence, latency 3
    pushAuto(1'b1);
    pulseStart();
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    check(initDone == 1'b0, "R8", "initDone during run", initDone, 0);
    // R9: triggers while busy are ignored
    repeat (25) @(negedge clk);
    pulseIssue();
    pulseStart();
    waitIdle();
    check(initDone == 1'b1, "R8", "initDone at end", initDone, 1);
    check(expQ.size() == 0, "R5", "pending commands", expQ.size(), 0);
    check(refreshEn == 1'b0, "R10", "refreshEn rate 0", refreshEn, 0);

    // R10: rate accepted after bring-up
    writeReg(3'd0, 1'b1, 4'd5);
    check(refreshRate == 4'd5, "R10", "rate stored", refreshRate, 5);
    check(refreshEn == 1'b1, "R10", "refreshEn", refreshEn, 1);

    // R2: hand-issued commands
    writeReg(3'd2, 1'b1, 4'd5);
    pushCmd(P_PRE, ADDR_W'(13'h400), -1, 2);
    pulseIssue();
    check(busy == 1'b1, "R2", "busy during precharge wait", busy, 1);
    waitIdle();
    writeReg(3'd4, 1'b1, 4'd5);
    pushCmd(P_REF, '0, -1, 2);
    pulseIssue();
    waitIdle();
    writeReg(3'd3, 1'b0, 4'd5);
    pushCmd(P_MRS, ADDR_W'(8'h2A), -1, 4);
    pulseIssue();
    waitIdle();
    writeReg(3'd1, 1'b0, 4'd5);
    pushCmd(P_NOP, '0, -1, 2);
    pulseIssue();
    waitIdle();
    check(expQ.size() == 0, "R2", "pending hand commands", expQ.size(), 0);
    // R2: normal and reserved field values send nothing
    seen = cmdSeen;
    writeReg(3'd0, 1'b0, 4'd5);
    pulseIssue();
    check(busy == 1'b0, "R2", "busy field 0", busy, 0);
    writeReg(3'd6, 1'b0, 4'd5);
    pulseIssue();
    check(busy == 1'b0, "R2", "busy field 6", busy, 0);
    repeat (3) @(negedge clk);
    check(cmdSeen == seen, "R2", "commands for field 0/6", cmdSeen, seen);

    // R8: rerun with latency 2, done cleared at start
    pushAuto(1'b0);
    pulseStart();
    check(initDone == 1'b0, "R8", "initDone cleared", initDone, 0);
    check(refreshEn == 1'b0, "R10", "refreshEn during rerun", refreshEn, 0);
    waitIdle();
    check(initDone == 1'b1, "R8", "initDone rerun", initDone, 1);
    check(expQ.size() == 0, "R5", "pending rerun", expQ.size(), 0);
    check(refreshEn == 1'b1, "R10", "refreshEn after rerun", refreshEn, 1);
    finish();
  end

endmodule